// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Address Sequencer

This block keeps a 12-bit mode word for a synchronous DRAM and uses it to turn single read or write requests into bursts of column addresses. The mode word sets how many beats a burst has, whether the columns within a burst count upward or are formed by XOR with the beat number, how many cycles read data lags its column, and whether writes use the full burst length or touch only one column.

A controller sends commands on a strobe with a two-bit type and a 12-bit address word. A mode load is taken only while the `banksIdle` input is high, the word has no reserved code, no burst or read return is under way, and the lockout window from an earlier load has expired. A read or write uses the low address bits as the start column and produces one column per cycle on `colAddr` qualified by `colValid`. `dataValid` marks the cycles in which the data bus carries the beat. A `burstStop` input ends any burst early and is the only way to end a full-page burst. Any refused command gives a one-cycle `cmdError` pulse and has no other effect.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, `colValid`, `dataValid` and `cmdError` are low, and the mode word is 0x020: one-beat bursts, upward order, read latency 2, writes using the programmed length.
- R2: A load command (type 00) made while `banksIdle` is low is refused and leaves the mode word unchanged.
- R3: A load whose word has a reserved code is refused and leaves the mode word unchanged. Bits 2:0 accept 000, 001, 010 and 011, and accept 111 only when bit 3 is 0. Bits 6:4 accept only 010 and 011. Bits 8:7 must be 00 and bits 11:10 must be 00.
- R4: Once a load is taken, each command in the following LOCK_CYCLES cycles (default 2) is refused.
- R5: A command that arrives while a burst is issuing columns, or while a read beat from the last three cycles is still waiting for its data, is refused.
- R6: Bits 2:0 set the number of beats: 000=1, 001=2, 010=4, 011=8. The burst starts with the start column in the cycle after the command.
- R7: With bit 3 = 0, the low log2(length) column bits count upward from the start column and wrap inside the aligned block. The upper bits stay fixed.
- R8: With bit 3 = 1, beat n uses column (start XOR n).
- R9: Code 111 gives a full-page burst. The column counts upward, wraps modulo 256, and runs until `burstStop` is sampled high. A high `burstStop` ends any active burst after the beat already on the port.
- R10: For a read (type 01), `dataValid` is high exactly N cycles after each column cycle, where N is 2 or 3 as set by bits 6:4.
- R11: For a write (type 10), `dataValid` is high in the same cycles as `colValid`. With bit 9 = 1, a write has exactly one beat, and reads keep the programmed length.
- R12: `cmdError` is high for exactly one cycle, in the cycle after a refused command. Type 11 is always refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe |
| cmdType | input | 2 | 00 load mode, 01 read, 10 write, 11 refused |
| cmdAddr | input | 12 | Mode word for a load, or start column (low COL_W bits) for a read or write |
| banksIdle | input | 1 | High when every bank is idle |
| burstStop | input | 1 | Ends the active burst |
| colAddr | output | COL_W | Column address of the current beat |
| colValid | output | 1 | A column is issued in this cycle |
| dataValid | output | 1 | The data bus carries a beat in this cycle |
| cmdError | output | 1 | Previous cycle's command was refused |

## Verification
A corrupted mode word shows up at the very next read or write. The burst has the wrong beat count, `colAddr` follows the wrong order, or `dataValid` appears one cycle off. It also shows up at the next load, which is then accepted or refused wrongly. A fault in the lockout counter or the busy tracking shows one cycle after the affected command: a `cmdError` pulse that should not be there, or a burst that starts when it should not. The reference model is compared with the design on every cycle, so each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int MODE_W = 12;
  localparam int MAX_CL = 3;
  localparam logic [MODE_W-1:0] MODE_RESET = 12'h020;

  typedef enum logic [1:0] {
    CMD_LOAD  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_BAD   = 2'b11
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic isRead;
    logic oneBeat;
  } burst_req_t;

  // field layout of the mode word, MSB first
  typedef struct packed {
    logic [1:0] rsvdHi;
    logic       wrSingle;
    logic [1:0] opMode;
    logic [2:0] latency;
    logic       interleave;
    logic [2:0] lenCode;
  } mode_t;

  function automatic logic mode_legal(input mode_t m);
    logic lenOk;
    logic latOk;
    lenOk = (m.lenCode <= 3'd3) || ((m.lenCode == 3'd7) && !m.interleave);
    latOk = (m.latency == 3'd2) || (m.latency == 3'd3);
    return lenOk && latOk && (m.opMode == 2'b00) && (m.rsvdHi == 2'b00);
  endfunction

endpackage

// File: rtl/burst_mode_ctrl.sv
module burst_mode_ctrl
  import burst_seq_pkg::*;
#(
  parameter int LOCK_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdType,
  input  logic [MODE_W-1:0] cmdAddr,
  input  logic              banksIdle,
  input  logic              pathBusy,
  output mode_t             modeQ,
  output burst_req_t        req,
  output logic              cmdError
);

  localparam int LOCK_W = (LOCK_CYCLES < 1) ? 1 : $clog2(LOCK_CYCLES + 1);
  localparam logic [LOCK_W-1:0] LOCK_INIT = LOCK_W'(LOCK_CYCLES);

  logic [LOCK_W-1:0] lockCnt;
  logic locked;
  logic loadOk;
  logic rwOk;
  logic reject;
  mode_t cand;

  assign locked = (lockCnt != '0);
  assign cand   = mode_t'(cmdAddr);

  // accept or refuse the command on the bus
  always_comb begin
    loadOk = 1'b0;
    rwOk   = 1'b0;
    reject = 1'b0;
    if (cmdValid) begin
      if (locked || pathBusy) begin
        reject = 1'b1;
      end else begin
        unique case (cmd_e'(cmdType))
          CMD_LOAD: begin
            if (banksIdle && mode_legal(cand)) loadOk = 1'b1;
            else                                reject = 1'b1;
          end
          CMD_READ, CMD_WRITE: rwOk = 1'b1;
          default:             reject = 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    req.start   = rwOk;
    req.isRead  = (cmd_e'(cmdType) == CMD_READ);
    req.oneBeat = (cmd_e'(cmdType) == CMD_WRITE) && modeQ.wrSingle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= mode_t'(MODE_RESET);
      lockCnt  <= '0;
      cmdError <= 1'b0;
    end else begin
      cmdError <= reject;
      if (loadOk) begin
        modeQ   <= cand;
        lockCnt <= LOCK_INIT;
      end else if (locked) begin
        lockCnt <= lockCnt - 1'b1;
      end
    end
  end

  // R2: a busy bank array freezes the mode word
  a_r2_busy_keeps_mode: assert property (@(posedge clk) disable iff (!rstN)
    !$past(banksIdle) |-> $stable(modeQ));

  // R3: only legal words are ever held
  a_r3_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    mode_legal(modeQ));

  // R4: no burst starts right after a load
  a_r4_lock_after_load: assert property (@(posedge clk) disable iff (!rstN)
    $past(loadOk) |-> !req.start);

  // R12: an error pulse always follows a command
  a_r12_err_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> $past(cmdValid));

endmodule

// File: rtl/burst_addr_path.sv
module burst_addr_path
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  burst_req_t       req,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  input  logic [2:0]       latency,
  input  logic [COL_W-1:0] startCol,
  input  logic             burstStop,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             dataValid,
  output logic             pathBusy
);

  logic             active;
  logic             curRead;
  logic             ilvQ;
  logic             fullQ;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] maskQ;
  logic [COL_W-1:0] colQ;
  logic [COL_W-1:0] lenMask;
  logic [COL_W-1:0] nextBeat;
  logic [COL_W-1:0] seqAddr;
  logic [COL_W-1:0] ilvAddr;
  logic [MAX_CL-1:0] rdPipe;
  logic             rdBeat;
  logic             lastBeat;
  logic             rdReturn;

  // mask of the column bits that move inside one burst
  always_comb begin
    unique case (lenCode)
      3'd0:    lenMask = '0;
      3'd1:    lenMask = COL_W'(1);
      3'd2:    lenMask = COL_W'(3);
      3'd3:    lenMask = COL_W'(7);
      default: lenMask = '1;
    endcase
  end

  assign nextBeat = beat + 1'b1;
  assign seqAddr  = (base & ~maskQ) | ((base + nextBeat) & maskQ);
  assign ilvAddr  = base ^ nextBeat;
  assign lastBeat = !fullQ && (beat == maskQ);
  assign rdBeat   = active && curRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      curRead <= 1'b0;
      ilvQ    <= 1'b0;
      fullQ   <= 1'b0;
      base    <= '0;
      beat    <= '0;
      maskQ   <= '0;
      colQ    <= '0;
    end else if (req.start) begin
      active  <= 1'b1;
      curRead <= req.isRead;
      ilvQ    <= interleave;
      fullQ   <= (lenCode == 3'd7) && !req.oneBeat;
      base    <= startCol;
      beat    <= '0;
      maskQ   <= req.oneBeat ? '0 : lenMask;
      colQ    <= startCol;
    end else if (active) begin
      if (burstStop || lastBeat) begin
        active <= 1'b0;
      end else begin
        beat <= nextBeat;
        colQ <= ilvQ ? ilvAddr : seqAddr;
      end
    end
  end

  // read beats waiting for their data slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPipe <= '0;
    else       rdPipe <= {rdPipe[MAX_CL-2:0], rdBeat};
  end

  // data return tap picked by the latency code
  always_comb begin
    rdReturn = 1'b0;
    for (int i = 2; i <= MAX_CL; i++) begin
      if (latency == 3'(i)) rdReturn = rdPipe[i-1];
    end
  end

  assign colAddr   = colQ;
  assign colValid  = active;
  assign dataValid = (active && !curRead) || rdReturn;
  assign pathBusy  = active || (rdPipe != '0);

  // R5: control never starts a burst over a busy path
  a_r5_start_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    req.start |-> !pathBusy);

  // R6: beat counter stays inside the burst
  a_r6_beat_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (active && !fullQ) |-> (beat <= maskQ));

  // R7: upward order moves by one inside the aligned block
  a_r7_seq_step: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active) && !ilvQ) |->
      ((((colQ - $past(colQ)) & maskQ) == COL_W'(1)) &&
       ((colQ & ~maskQ) == ($past(colQ) & ~maskQ))));

  // R8: XOR order
  a_r8_ilv_xor: assert property (@(posedge clk) disable iff (!rstN)
    (active && ilvQ) |-> ((colQ ^ base) == beat));

  // R10: read data returns after the programmed latency
  a_r10_cl2_return: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdBeat, 2) && latency == 3'd2) |-> dataValid);
  a_r10_cl3_return: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdBeat, 3) && latency == 3'd3) |-> dataValid);

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W       = 8,
  parameter int LOCK_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdType,
  input  logic [MODE_W-1:0] cmdAddr,
  input  logic              banksIdle,
  input  logic              burstStop,
  output logic [COL_W-1:0]  colAddr,
  output logic              colValid,
  output logic              dataValid,
  output logic              cmdError
);

  mode_t      modeQ;
  burst_req_t req;
  logic       pathBusy;

  burst_mode_ctrl #(
    .LOCK_CYCLES(LOCK_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdType  (cmdType),
    .cmdAddr  (cmdAddr),
    .banksIdle(banksIdle),
    .pathBusy (pathBusy),
    .modeQ    (modeQ),
    .req      (req),
    .cmdError (cmdError)
  );

  burst_addr_path #(
    .COL_W(COL_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .req       (req),
    .lenCode   (modeQ.lenCode),
    .interleave(modeQ.interleave),
    .latency   (modeQ.latency),
    .startCol  (cmdAddr[COL_W-1:0]),
    .burstStop (burstStop),
    .colAddr   (colAddr),
    .colValid  (colValid),
    .dataValid (dataValid),
    .pathBusy  (pathBusy)
  );

endmodule

// File: tb/sdram_burst_seq_bench.sv
module sdram_burst_seq_bench;

  localparam int LOCK = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdType = 2'b00;
  logic [11:0] cmdAddr = 12'h000;
  logic        banksIdle = 1'b1;
  logic        burstStop = 1'b0;
  logic [7:0]  colAddr;
  logic        colValid;
  logic        dataValid;
  logic        cmdError;

  int    errors = 0;
  int    checks = 0;
  string phase = "R1";

  sdram_burst_seq u_sdram_burst_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdAddr(cmdAddr), .banksIdle(banksIdle), .burstStop(burstStop),
    .colAddr(colAddr), .colValid(colValid), .dataValid(dataValid),
    .cmdError(cmdError)
  );

  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  int mMode, mLock, mBeat, mLen, mBase, mCol, mHist;
  bit mActive, mRead, mIlv, mErr, expDv;

  function automatic bit legalWord(int a);
    int bl, ilv, cl, op, hi;
    bl = a & 7; ilv = (a >> 3) & 1; cl = (a >> 4) & 7;
    op = (a >> 7) & 3; hi = (a >> 10) & 3;
    return (bl <= 3 || (bl == 7 && ilv == 0)) && (cl == 2 || cl == 3)
           && op == 0 && hi == 0;
  endfunction

  always @(posedge clk) begin : model
    bit busy, rej, startNow, loadNow, single;
    int blk, cl;
    if (!rstN) begin
      mMode = 'h020; mLock = 0; mActive = 0; mHist = 0; mErr = 0; expDv = 0;
      mBeat = 0; mLen = 1; mBase = 0; mCol = 0; mRead = 0; mIlv = 0;
    end else begin
      busy = mActive || ((mHist & 'b1110) != 0);
      rej = 0; startNow = 0; loadNow = 0;
      if (cmdValid) begin
        if (mLock > 0 || busy) rej = 1;
        else if (cmdType == 2'b00) begin
          if (banksIdle && legalWord(int'(cmdAddr))) loadNow = 1; else rej = 1;
        end else if (cmdType == 2'b11) rej = 1;
        else startNow = 1;
      end
      if (loadNow) mLock = LOCK; else if (mLock > 0) mLock--;
      if (startNow) begin
        mActive = 1; mBeat = 0; mBase = int'(cmdAddr) & 255; mCol = mBase;
        mRead = (cmdType == 2'b01); mIlv = ((mMode >> 3) & 1) != 0;
        single = !mRead && (((mMode >> 9) & 1) != 0);
        mLen = single ? 1 : ((mMode & 7) == 7 ? 0 : (1 << (mMode & 7)));
      end else if (mActive) begin
        if (burstStop || (mLen != 0 && mBeat == mLen - 1)) mActive = 0;
        else begin
          mBeat++;
          if (mIlv) mCol = mBase ^ mBeat;
          else begin
            blk = (mLen == 0) ? 256 : mLen;
            mCol = (mBase - (mBase % blk)) + ((mBase % blk) + mBeat) % blk;
          end
        end
      end
      if (loadNow) mMode = int'(cmdAddr);
      mHist = ((mHist << 1) | int'(mActive && mRead)) & 'hF;
      cl = (mMode >> 4) & 7;
      expDv = (mActive && !mRead) || (((mHist >> cl) & 1) != 0);
      mErr = rej;
    end
  end

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", phase, what, act, exp, $time);
    end
  endtask

  // compare on every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(colValid == mActive, "colValid", colValid, mActive);
      if (mActive) check(int'(colAddr) == mCol, "colAddr", colAddr, mCol);
      check(dataValid == expDv, "dataValid", dataValid, expDv);
      check(cmdError == mErr, "cmdError", cmdError, mErr);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(logic [1:0] t, logic [11:0] a);
    @(negedge clk); cmdValid = 1'b1; cmdType = t; cmdAddr = a;
    @(negedge clk); cmdValid = 1'b0;
  endtask

  task automatic load(logic [11:0] a);
    issue(2'b00, a); idle(LOCK + 1);
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL %s watchdog actual=hung expected=done", phase);
    finish();
  end

  initial begin : stimulus
    idle(3);
    // R1: reset state on the ports
    phase = "R1";
    check(colValid == 0 && dataValid == 0 && cmdError == 0, "reset outputs",
          {colValid, dataValid, cmdError}, 0);
    @(negedge clk); rstN = 1'b1;
    idle(2);
    issue(2'b01, 12'h035); idle(8);          // one beat, latency 2
    issue(2'b10, 12'h012); idle(6);

    // R6 / R7: four beats upward with wrap, then eight
    phase = "R7";
    load(12'h022);
    issue(2'b01, 12'h00E); idle(10);
    issue(2'b10, 12'h0A5); idle(10);
    phase = "R6";
    load(12'h023);
    issue(2'b01, 12'h0F3); idle(14);
    load(12'h021);
    issue(2'b10, 12'h041); idle(6);

    // R2: load refused while banks busy, old mode still used
    phase = "R2";
    banksIdle = 1'b0;
    issue(2'b00, 12'h030); idle(3);
    banksIdle = 1'b1;
    issue(2'b01, 12'h040); idle(8);

    // R3: every reserved field refused
    phase = "R3";
    issue(2'b00, 12'h024); idle(3);
    issue(2'b00, 12'h02F); idle(3);
    issue(2'b00, 12'h012); idle(3);
    issue(2'b00, 12'h042); idle(3);
    issue(2'b00, 12'h0A2); idle(3);
    issue(2'b00, 12'h422); idle(3);
    issue(2'b10, 12'h077); idle(6);

    // R8 / R10: eight beats XOR order with latency 3
    phase = "R8";
    load(12'h03B);
    issue(2'b01, 12'h005); idle(14);
    phase = "R10";
    issue(2'b01, 12'h0CA); idle(14);

    // R4: back-to-back commands after a load
    phase = "R4";
    @(negedge clk); cmdValid = 1'b1; cmdType = 2'b00; cmdAddr = 12'h021;
    @(negedge clk); cmdType = 2'b01; cmdAddr = 12'h010;
    @(negedge clk); cmdAddr = 12'h020;
    @(negedge clk); cmdAddr = 12'h031;
    @(negedge clk); cmdValid = 1'b0;
    idle(8);

    // R5: commands during burst and during read return
    phase = "R5";
    load(12'h023);
    issue(2'b01, 12'h008);
    issue(2'b10, 12'h010);
    idle(5);
    issue(2'b00, 12'h022);
    issue(2'b01, 12'h011);
    idle(6);

    // R9: full page wraps past 255, then stop
    phase = "R9";
    load(12'h027);
    issue(2'b01, 12'h0FC); idle(300);
    @(negedge clk); burstStop = 1'b1;
    @(negedge clk); burstStop = 1'b0;
    idle(6);
    load(12'h023);
    issue(2'b10, 12'h020); idle(2);
    @(negedge clk); burstStop = 1'b1;
    @(negedge clk); burstStop = 1'b0;
    idle(8);

    // R11: single-location writes, reads keep their length
    phase = "R11";
    load(12'h222);
    issue(2'b10, 12'h033); idle(4);
    issue(2'b01, 12'h033); idle(10);

    // R12: reserved type and error pulse width
    phase = "R12";
    issue(2'b11, 12'h000); idle(3);
    check(cmdError == 0, "error pulse ended", cmdError, 0);
    idle(4);
    finish();
  end

endmodule